// File: doc/BRIEF.md
# Chained Sprite Parameter Resolver

This block takes sprite attribute records one at a time, in sprite index order, and turns each into the parameters a sprite renderer needs to draw it. These are absolute 9-bit X and Y, the final visibility, whether 4-bit patterns are in use and which half of the pattern is used, the X and Y magnification, and the pattern, palette and transform fields, which are passed through. Each record is four bytes with an optional fifth. A flag in the fourth byte says whether the fifth byte carries meaning. When the flag is clear, the fifth byte is taken as zero.

A record is either an anchor or a relative sprite. An anchor is drawn from its own fields, and its position, visibility and colour depth are stored. A relative sprite adds its own coordinates to the stored anchor position, modulo 512. It is drawn only when both it and the anchor are visible. It takes its colour depth from the anchor. A frame-start pulse clears the stored anchor, so a relative sprite that arrives before any anchor in a frame is hidden.

Records enter through a valid/ready handshake. Each accepted record appears one cycle later in an output register, which is held while the consumer stalls.

Top module: `spr_rel_resolver`

## Requirements
- R1: When bit 6 of byte 3 is 0, byte 4 is treated as all zeros, whatever its value.
- R2: Byte 4 bit 7 (H) and bit 6 (N6) select the type. If H=1, the record is a 4-bit anchor and its pattern half equals N6. If H=0 and N6=0, it is an 8-bit anchor with half 0. If H=0 and N6=1, it is a relative sprite (out_rel=1).
- R3: out_xscale is byte 4 bits 4:3 and out_yscale is byte 4 bits 2:1. Code 0 means 16 px, 1 means 32 px, 2 means 64 px and 3 means 128 px. These are the record's own codes for both types.
- R4: For an anchor, X is {byte2 bit0, byte0}, Y is {byte4 bit0, byte1}, and visibility is byte 3 bit 7. Pattern is byte 3 bits 5:0, palette offset is byte 2 bits 7:4, and transform is byte 2 bits 3:1. The same pass-through applies to relative sprites.
- R5: A relative sprite's X and Y are its own 9-bit X and Y plus those of the stored anchor, modulo 512.
- R6: A relative sprite is visible only if its own visibility bit and the stored anchor's visibility are both 1.
- R7: A relative sprite uses 4-bit mode when the stored anchor has H=1. Its pattern half is then byte 4 bit 5; otherwise the half is 0.
- R8: A relative sprite leaves the stored anchor unchanged. Every anchor record replaces it.
- R9: A frame_start pulse clears the stored anchor to invisible, position 0 and H=0. An anchor accepted in the same cycle is stored instead, and a relative record accepted in that cycle sees the cleared anchor.
- R10: in_ready is high when the output register is empty or being read. An accepted record appears on the outputs at the next clock edge with out_valid high. The outputs do not change while out_valid is high and out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Clears stored anchor at frame start |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Record can be taken |
| in_b0 | input | 8 | X low byte |
| in_b1 | input | 8 | Y low byte |
| in_b2 | input | 8 | Palette, transform, X bit 8 |
| in_b3 | input | 8 | Visible, extension flag, pattern |
| in_b4 | input | 8 | Optional fifth byte |
| out_valid | output | 1 | Resolved parameters present |
| out_ready | input | 1 | Consumer takes parameters |
| out_x | output | 9 | Absolute X |
| out_y | output | 9 | Absolute Y |
| out_vis | output | 1 | Sprite drawn |
| out_four | output | 1 | 4-bit pattern mode |
| out_half | output | 1 | Pattern half select |
| out_xscale | output | 2 | X magnification code |
| out_yscale | output | 2 | Y magnification code |
| out_rel | output | 1 | Record was relative |
| out_pattern | output | 6 | Pattern index |
| out_pal | output | 4 | Palette offset |
| out_xform | output | 3 | Mirror/rotate bits |

## Verification
The sweep pairs anchors with relative sprites over coordinates near 0, 255 and 511, so that the sums cross the 512 boundary. A design that carried into a tenth bit, or that dropped the ninth bit, would misplace the sprite. Every combination of anchor and relative visibility, anchor H and relative bit 5 is covered. An AND gate replaced by OR, or a 4-bit mode taken from the record instead of from the anchor, would show up at once. Records with the extension flag clear but a nonzero fifth byte catch a design that decodes byte 4 anyway. A relative sprite right after frame_start catches a stale anchor, and a stalled output catches a register that is overwritten while it is held.

// File: rtl/spr_rel_pkg.sv
package spr_rel_pkg;
  localparam int BYTE_W  = 8;
  localparam int COORD_W = 9;
  localparam int SCL_W   = 2;
  localparam int PAT_W   = 6;
  localparam int PAL_W   = 4;
  localparam int XF_W    = 3;

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [COORD_W-1:0] coord_t;

  // Decoded record
  typedef struct packed {
    logic             is_rel;
    logic             h;
    logic             n6;
    logic             rel_half;
    logic [SCL_W-1:0] xs;
    logic [SCL_W-1:0] ys;
    coord_t           x;
    coord_t           y;
    logic             vis;
    logic [PAT_W-1:0] pat;
    logic [PAL_W-1:0] pal;
    logic [XF_W-1:0]  xf;
  } fields_t;

  // Stored anchor state
  typedef struct packed {
    coord_t x;
    coord_t y;
    logic   vis;
    logic   h;
  } anchor_t;

  // Resolved draw parameters
  typedef struct packed {
    coord_t           x;
    coord_t           y;
    logic             vis;
    logic             four;
    logic             half;
    logic [SCL_W-1:0] xs;
    logic [SCL_W-1:0] ys;
    logic             rel;
    logic [PAT_W-1:0] pat;
    logic [PAL_W-1:0] pal;
    logic [XF_W-1:0]  xf;
  } res_t;

  // Modular coordinate sum: carry out of the top bit is discarded
  function automatic coord_t coord_wrap_add(input coord_t a, input coord_t b);
    logic [COORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[COORD_W-1:0];
  endfunction

  // Fifth byte as seen by the decoder
  function automatic byte_t ext_byte(input logic present, input byte_t raw);
    return present ? raw : '0;
  endfunction
endpackage

// File: rtl/spr_field_decode.sv
module spr_field_decode
  import spr_rel_pkg::*;
(
  input  byte_t   b0,
  input  byte_t   b1,
  input  byte_t   b2,
  input  byte_t   b3,
  input  byte_t   b4,
  output fields_t fld
);
  byte_t e;

  always_comb begin
    e            = ext_byte(b3[6], b4);
    fld.h        = e[7];
    fld.n6       = e[6];
    fld.is_rel   = ~e[7] & e[6];
    fld.rel_half = e[5];
    fld.xs       = e[4:3];
    fld.ys       = e[2:1];
    fld.x        = {b2[0], b0};
    fld.y        = {e[0], b1};
    fld.vis      = b3[7];
    fld.pat      = b3[5:0];
    fld.pal      = b2[7:4];
    fld.xf       = b2[3:1];
  end
endmodule

// File: rtl/spr_anchor_store.sv
module spr_anchor_store
  import spr_rel_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frame_start,
  input  logic    load,
  input  fields_t fld,
  output anchor_t anc_q,
  output anchor_t anc_eff
);
  anchor_t anc_d;

  always_comb begin
    anc_eff = frame_start ? '0 : anc_q;
    anc_d   = anc_eff;
    if (load) begin
      anc_d.x   = fld.x;
      anc_d.y   = fld.y;
      anc_d.vis = fld.vis;
      anc_d.h   = fld.h;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) anc_q <= '0;
    else        anc_q <= anc_d;
  end
endmodule

// File: rtl/spr_param_resolve.sv
module spr_param_resolve
  import spr_rel_pkg::*;
(
  input  fields_t fld,
  input  anchor_t anc,
  output res_t    res
);
  always_comb begin
    res.xs  = fld.xs;
    res.ys  = fld.ys;
    res.pat = fld.pat;
    res.pal = fld.pal;
    res.xf  = fld.xf;
    res.rel = fld.is_rel;
    if (fld.is_rel) begin
      res.x    = coord_wrap_add(anc.x, fld.x);
      res.y    = coord_wrap_add(anc.y, fld.y);
      res.vis  = anc.vis & fld.vis;
      res.four = anc.h;
      res.half = anc.h & fld.rel_half;
    end else begin
      res.x    = fld.x;
      res.y    = fld.y;
      res.vis  = fld.vis;
      res.four = fld.h;
      res.half = fld.h & fld.n6;
    end
  end
endmodule

// File: rtl/spr_rel_resolver.sv
module spr_rel_resolver
  import spr_rel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_b0,
  input  logic [7:0] in_b1,
  input  logic [7:0] in_b2,
  input  logic [7:0] in_b3,
  input  logic [7:0] in_b4,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [8:0] out_x,
  output logic [8:0] out_y,
  output logic       out_vis,
  output logic       out_four,
  output logic       out_half,
  output logic [1:0] out_xscale,
  output logic [1:0] out_yscale,
  output logic       out_rel,
  output logic [5:0] out_pattern,
  output logic [3:0] out_pal,
  output logic [2:0] out_xform
);
  fields_t fld;
  anchor_t anc_q;
  anchor_t anc_eff;
  res_t    res;
  res_t    res_q;

  // Named events for the checker
  logic acc;
  logic anc_load;
  logic fld_rel;
  logic fld_h;

  assign in_ready = ~out_valid | out_ready;
  assign acc      = in_valid & in_ready;
  assign fld_rel  = fld.is_rel;
  assign fld_h    = fld.h;
  assign anc_load = acc & ~fld.is_rel;

  spr_field_decode u_dec (
    .b0(in_b0), .b1(in_b1), .b2(in_b2), .b3(in_b3), .b4(in_b4), .fld(fld)
  );

  spr_anchor_store u_anc (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .load(anc_load), .fld(fld), .anc_q(anc_q), .anc_eff(anc_eff)
  );

  spr_param_resolve u_res (
    .fld(fld), .anc(anc_eff), .res(res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      if (acc) begin
        out_valid <= 1'b1;
        res_q     <= res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_x       = res_q.x;
  assign out_y       = res_q.y;
  assign out_vis     = res_q.vis;
  assign out_four    = res_q.four;
  assign out_half    = res_q.half;
  assign out_xscale  = res_q.xs;
  assign out_yscale  = res_q.ys;
  assign out_rel     = res_q.rel;
  assign out_pattern = res_q.pat;
  assign out_pal     = res_q.pal;
  assign out_xform   = res_q.xf;
endmodule

// File: rtl/spr_rel_resolver_chk.sv
module spr_rel_resolver_chk
  import spr_rel_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       acc,
  input logic       anc_load,
  input logic       fld_rel,
  input logic       fld_h,
  input logic [7:0] in_b3,
  input anchor_t    anc_q,
  input logic       out_valid,
  input logic       out_ready,
  input logic [8:0] out_x,
  input logic [8:0] out_y,
  input logic       out_vis,
  input logic       out_four,
  input logic       out_rel
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y)
      && $stable(out_vis) && $stable(out_four) && $stable(out_rel));

  // R10
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R6
  rel_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && fld_rel && !in_b3[7] |=> !out_vis);

  // R8
  anchor_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && fld_rel && !frame_start |=> $stable(anc_q));

  // R9
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !anc_load |=> !anc_q.vis && !anc_q.h);

  // R2
  anchor_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anc_load && fld_h |=> out_four && !out_rel);
endmodule

bind spr_rel_resolver spr_rel_resolver_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .acc(acc),
  .anc_load(anc_load), .fld_rel(fld_rel), .fld_h(fld_h), .in_b3(in_b3),
  .anc_q(anc_q), .out_valid(out_valid), .out_ready(out_ready),
  .out_x(out_x), .out_y(out_y), .out_vis(out_vis), .out_four(out_four),
  .out_rel(out_rel)
);

// File: tb/sim_spr_rel_resolver.sv
module sim_spr_rel_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_b0 = '0, in_b1 = '0, in_b2 = '0, in_b3 = '0, in_b4 = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [8:0] out_x, out_y;
  logic out_vis, out_four, out_half, out_rel;
  logic [1:0] out_xscale, out_yscale;
  logic [5:0] out_pattern;
  logic [3:0] out_pal;
  logic [2:0] out_xform;

  int checks = 0;
  int errors = 0;
  int ax = 0, ay = 0, av = 0, ah = 0;
  logic [38:0] expv;

  always #10 clk = ~clk;

  spr_rel_resolver u0 (.*);

  function automatic logic [38:0] got();
    return {out_x, out_y, out_vis, out_four, out_half, out_xscale, out_yscale,
            out_rel, out_pattern, out_pal, out_xform};
  endfunction

  task automatic check(input string tag, input logic [38:0] act, input logic [38:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent model: returns expected outputs and updates anchor state
  function automatic logic [38:0] model(input logic [7:0] b0, b1, b2, b3, b4);
    int e, ox, oy, ovis, x, y, vis, four, half, rel;
    e  = b3[6] ? int'(b4) : 0;
    ox = int'(b0) + 256 * int'(b2[0]);
    oy = int'(b1) + 256 * (e % 2);
    ovis = int'(b3[7]);
    if ((e / 64) % 4 == 1) begin
      rel = 1; x = (ax + ox) % 512; y = (ay + oy) % 512;
      vis = (av == 1 && ovis == 1) ? 1 : 0;
      four = ah; half = (ah == 1) ? (e / 32) % 2 : 0;
    end else begin
      rel = 0; x = ox; y = oy; vis = ovis;
      four = e / 128; half = (four == 1) ? (e / 64) % 2 : 0;
      ax = ox; ay = oy; av = ovis; ah = four;
    end
    return {9'(x), 9'(y), 1'(vis), 1'(four), 1'(half), 2'((e / 8) % 4),
            2'((e / 2) % 4), 1'(rel), b3[5:0], b2[7:4], b2[3:1]};
  endfunction

  task automatic send(input logic [7:0] b0, b1, b2, b3, b4, input string tag);
    @(negedge clk);
    in_b0 = b0; in_b1 = b1; in_b2 = b2; in_b3 = b3; in_b4 = b4; in_valid = 1'b1;
    expv = model(b0, b1, b2, b3, b4);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, got(), expv);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int xs[4] = '{0, 255, 300, 511};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 reset", {37'd0, out_valid, in_ready}, {37'd0, 1'b0, 1'b1});
    rst_n = 1'b1;

    // R1: extension flag clear, nonzero fifth byte ignored
    send(8'h12, 8'h34, 8'h51, 8'h85, 8'hFF, "R1 ext clear");
    send(8'h12, 8'h34, 8'h51, 8'h85, 8'h7F, "R1 ext clear relative pattern");
    // R2/R3/R4: every type and scale code on anchors
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 16; s++)
        send(8'(t * 37), 8'(s * 11), 8'(s * 16 + t), 8'hC0 | 8'(s),
             8'((t == 1 ? 2 : t) * 64 + s * 2 + (s % 2)), "R2 R3 R4 anchor types");

    // R5/R6/R7/R8: anchor + relative sweep
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 16; k++) begin
          logic [8:0] a9, r9;
          a9 = 9'(xs[i]); r9 = 9'(xs[j]);
          send(a9[7:0], a9[7:0], {7'd0, a9[8]}, {k[0], 7'h40},
               {k[1], 6'd0, a9[8]}, "R4 anchor");
          send(r9[7:0], 8'(xs[3 - j]), {7'd0, r9[8]}, {k[2], 7'h4A},
               {2'b01, k[3], 5'b10110}, "R5 R6 R7 relative sum");
          send(8'd1, 8'd2, 8'd0, 8'hC1, 8'h40, "R8 anchor unchanged by relative");
        end

    // R9: relative before any anchor after frame_start
    send(8'd100, 8'd100, 8'd0, 8'hC0, 8'h80, "R9 setup");
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    ax = 0; ay = 0; av = 0; ah = 0;
    send(8'd7, 8'd9, 8'd0, 8'hC0, 8'h60, "R9 hidden after frame");

    // R10: backpressure
    @(negedge clk); out_ready = 1'b0;
    send(8'd3, 8'd4, 8'd0, 8'h80, 8'h00, "R10 first held");
    @(negedge clk);
    in_b0 = 8'd8; in_b1 = 8'd9; in_b3 = 8'h80; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R10 stall", {in_ready, got()[38:1]}, {1'b0, expv[38:1]});
    expv = model(8'd8, 8'd9, 8'd0, 8'h80, 8'h00);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    check("R10 release", got(), expv);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule